// File: doc/BRIEF.md
# Debug Serial Slave Interface

This block is the target end of a clocked serial debug link used while a processor is halted. An external master drives a serial clock and a serial data line into the chip. The block drives one serial data line back. Every flop in the block runs on the fast processor clock. The serial clock is oversampled through a synchronizer and used only to enable state changes. No logic is clocked by it directly.

Each exchange is a 17-bit full-duplex frame, made of one control/status bit and a 16-bit word. As the master shifts a command in, the block shifts a response out, most significant bit first. When a frame completes, the block delivers the received word and its control bit on a parallel port as a one-cycle pulse. It takes the next response through a ready/valid port. If no response is waiting, the block answers with a not-ready status and a zero word.

After each frame the block ignores the serial clock for a fixed recovery window. The master has to count bits itself, because the output line carries no start marker.

Top module: `dbg_serial_slave`

## Requirements
- R1: A frame is 17 accepted serial-clock rising edges, MSB first. With the status bit placed first, which is the default, frame bit 16 is the control bit and bits 15..0 are the word. On the 17th accepted edge, `rx_valid_o` is high for exactly one cycle, with `rx_ctrl_o` and `rx_word_o` holding the received bits.
- R2: For each bit of a frame, `sdo_o` presents the response frame MSB first: the status bit first, then word bits 15..0. The line moves to the next bit after each accepted edge.
- R3: `sclk_i` and `sdi_i` pass through a two-flop synchronizer. Suppose `sclk_i` is first sampled high at clock edge N after being sampled low. Then the shift state and `rx_valid_o` update at edge N+2, and `sdo_o` changes at edge N+3, not before.
- R4: A rising edge of the serial clock is recognized only after at least one low sample. Holding `sclk_i` high for any number of cycles counts as a single bit, and one low sample between bits is enough.
- R5: For 32 processor clocks after a frame completes, serial-clock edges are ignored. They neither shift data nor advance the bit position.
- R6: `rsp_ready_o` is high while no response is pending. A response taken while no frame is in progress is sent in the next frame, as {`rsp_stat_i`, `rsp_word_i`}.
- R7: If no response is pending when a frame begins, the block sends status 1 (not-ready) followed by a zero word.
- R8: While `rst_ni` is low, `sdo_o` and `rx_valid_o` are low, `rsp_ready_o` is high, and the bit position returns to zero.
- R9: A response taken during a frame does not alter the frame in progress. While that response is pending, `rsp_ready_o` is low, so a further offer is not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Processor clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | Serial clock from the master, asynchronous |
| sdi_i | input | 1 | Serial data from the master |
| sdo_o | output | 1 | Registered serial data to the master |
| rx_valid_o | output | 1 | One-cycle pulse when a frame completes |
| rx_ctrl_o | output | 1 | Received control bit |
| rx_word_o | output | 16 | Received word |
| rsp_valid_i | input | 1 | Response offer |
| rsp_ready_o | output | 1 | Response slot empty |
| rsp_stat_i | input | 1 | Response status bit (1 = not ready) |
| rsp_word_i | input | 16 | Response word |

## Verification
The hardest case to reach is a serial-clock edge that lands inside the recovery window, because the master can produce one only by starting a new bit right after the 17th. The bench raises the clock for one stray bit as soon as a frame ends. It then runs a full frame once the window has passed. If the stray bit had been accepted, the bit alignment of both the received word and the transmitted response would be off by one. A second hard case is a response offered partway through a frame. The bench pauses the serial clock after a few bits, offers two responses back to back, and checks which of them reaches the line in the following frame.

// File: rtl/dss_pkg.sv
package dss_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_GAP   = 2'd2
  } dss_state_e;
endpackage

// File: rtl/dss_sync.sv
module dss_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_q <= '0;
    end else begin
      for (int k = STAGES - 1; k > 0; k--) stg_q[k] <= stg_q[k-1];
      stg_q[0] <= d_i;
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/dss_resp_hold.sv
module dss_resp_hold #(
  parameter int FRAME_W = 17
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic [FRAME_W-1:0] frame_i,
  output logic               ready_o,
  output logic               pend_o,
  output logic [FRAME_W-1:0] frame_o,
  input  logic               take_i
);
  logic               full_q;
  logic [FRAME_W-1:0] hold_q;

  assign ready_o = !full_q;
  assign pend_o  = full_q;
  assign frame_o = hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      hold_q <= '0;
    end else if (take_i) begin
      full_q <= 1'b0;
    end else if (valid_i && !full_q) begin
      full_q <= 1'b1;
      hold_q <= frame_i;
    end
  end

  AST_TAKE_NEEDS_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |-> full_q); // R6
  AST_PEND_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_q && !take_i) |=> (full_q && $stable(hold_q))); // R9
endmodule

// File: rtl/dss_shifter.sv
module dss_shifter
  import dss_pkg::*;
#(
  parameter int               FRAME_W    = 17,
  parameter int               GAP_CYC    = 32,
  parameter logic [FRAME_W-1:0] IDLE_FRAME = '0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sclk_s_i,
  input  logic               sdi_s_i,
  input  logic               pend_i,
  input  logic [FRAME_W-1:0] pend_frame_i,
  output logic               take_o,
  output logic [FRAME_W-1:0] rx_frame_o,
  output logic               rx_valid_o,
  output logic               sdo_o
);
  localparam int CNT_W = $clog2(FRAME_W);
  localparam int GAP_W = $clog2(GAP_CYC + 1);

  dss_state_e         state_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [GAP_W-1:0]   gap_q;
  logic [FRAME_W-1:0] rx_sr_q;
  logic [FRAME_W-1:0] tx_sr_q;
  logic               sclk_prev_q;
  logic               rx_valid_q;
  logic               sdo_q;

  logic rise, accept, last_bit;

  // rising edge only after a low sample
  assign rise     = sclk_s_i && !sclk_prev_q;
  assign accept   = rise && (state_q != ST_GAP);
  assign last_bit = accept && (cnt_q == CNT_W'(FRAME_W - 1));
  assign take_o   = (state_q == ST_IDLE) && !accept && pend_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sclk_prev_q <= 1'b0;
    else         sclk_prev_q <= sclk_s_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      cnt_q      <= '0;
      gap_q      <= '0;
      rx_sr_q    <= '0;
      tx_sr_q    <= IDLE_FRAME;
      rx_valid_q <= 1'b0;
    end else begin
      rx_valid_q <= 1'b0;
      unique case (state_q)
        ST_IDLE, ST_SHIFT: begin
          if (accept) begin
            rx_sr_q <= {rx_sr_q[FRAME_W-2:0], sdi_s_i};
            if (last_bit) begin
              rx_valid_q <= 1'b1;
              tx_sr_q    <= IDLE_FRAME;
              cnt_q      <= '0;
              gap_q      <= GAP_W'(GAP_CYC);
              state_q    <= ST_GAP;
            end else begin
              tx_sr_q <= {tx_sr_q[FRAME_W-2:0], 1'b0};
              cnt_q   <= cnt_q + 1'b1;
              state_q <= ST_SHIFT;
            end
          end else if (take_o) begin
            tx_sr_q <= pend_frame_i;
          end
        end
        ST_GAP: begin
          gap_q <= gap_q - 1'b1;
          if (gap_q == GAP_W'(1)) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // output follows the state change by one clock
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sdo_q <= 1'b0;
    else         sdo_q <= tx_sr_q[FRAME_W-1];
  end

  assign rx_frame_o = rx_sr_q;
  assign rx_valid_o = rx_valid_q;
  assign sdo_o      = sdo_q;

  AST_RX_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_q |=> !rx_valid_q); // R1
  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CNT_W'(FRAME_W)); // R1
  AST_GAP_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_GAP) |=> ($stable(rx_sr_q) && cnt_q == '0)); // R5
  AST_MIDFRAME_TX_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SHIFT && !accept) |=> $stable(tx_sr_q)); // R9
  AST_GAP_AFTER_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_q |-> (state_q == ST_GAP)); // R5
endmodule

// File: rtl/dbg_serial_slave.sv
module dbg_serial_slave #(
  parameter int   WORD_W      = 16,
  parameter int   SYNC_STAGES = 2,
  parameter int   GAP_CYC     = 32,
  parameter bit   STAT_FIRST  = 1'b1,
  parameter logic NOT_READY   = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              sdi_i,
  output logic              sdo_o,
  output logic              rx_valid_o,
  output logic              rx_ctrl_o,
  output logic [WORD_W-1:0] rx_word_o,
  input  logic              rsp_valid_i,
  output logic              rsp_ready_o,
  input  logic              rsp_stat_i,
  input  logic [WORD_W-1:0] rsp_word_i
);
  localparam int FRAME_W = WORD_W + 1;
  localparam logic [FRAME_W-1:0] IDLE_FRAME =
    STAT_FIRST ? {NOT_READY, {WORD_W{1'b0}}} : {{WORD_W{1'b0}}, NOT_READY};

  logic [1:0]         sync_q;
  logic [FRAME_W-1:0] rsp_frame, pend_frame, rx_frame;
  logic               pend, take;

  dss_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({sclk_i, sdi_i}),
    .q_o   (sync_q)
  );

  generate
    if (STAT_FIRST) begin : g_stat_msb
      assign rsp_frame = {rsp_stat_i, rsp_word_i};
      assign rx_ctrl_o = rx_frame[FRAME_W-1];
      assign rx_word_o = rx_frame[WORD_W-1:0];
    end else begin : g_stat_lsb
      assign rsp_frame = {rsp_word_i, rsp_stat_i};
      assign rx_ctrl_o = rx_frame[0];
      assign rx_word_o = rx_frame[FRAME_W-1:1];
    end
  endgenerate

  dss_resp_hold #(.FRAME_W(FRAME_W)) u_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(rsp_valid_i),
    .frame_i(rsp_frame),
    .ready_o(rsp_ready_o),
    .pend_o (pend),
    .frame_o(pend_frame),
    .take_i (take)
  );

  dss_shifter #(
    .FRAME_W   (FRAME_W),
    .GAP_CYC   (GAP_CYC),
    .IDLE_FRAME(IDLE_FRAME)
  ) u_shift (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sclk_s_i    (sync_q[1]),
    .sdi_s_i     (sync_q[0]),
    .pend_i      (pend),
    .pend_frame_i(pend_frame),
    .take_o      (take),
    .rx_frame_o  (rx_frame),
    .rx_valid_o  (rx_valid_o),
    .sdo_o       (sdo_o)
  );

  AST_READY_WHEN_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take |=> rsp_ready_o); // R6
endmodule

// File: tb/tb_dbg_serial_slave.sv
module tb_dbg_serial_slave;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 6;

  localparam logic [16:0] CMD_VEC [NVEC] = '{17'h1A5C3, 17'h00001, 17'h18000,
                                            17'h0FFFF, 17'h13C3C, 17'h05A5A};
  localparam logic [16:0] RSP_VEC [NVEC] = '{17'h0BEEF, 17'h1FFFF, 17'h00000,
                                            17'h08001, 17'h0C3A5, 17'h17E81};
  localparam int HI_VEC [NVEC] = '{3, 2, 4, 20, 60, 7};
  localparam int LO_VEC [NVEC] = '{2, 3, 1, 1, 5, 7};

  logic clk_i = 1'b0, rst_ni = 1'b0, sclk_i = 1'b0, sdi_i = 1'b0;
  logic rsp_valid_i = 1'b0, rsp_stat_i = 1'b0;
  logic [15:0] rsp_word_i = '0;
  logic sdo_o, rx_valid_o, rx_ctrl_o, rsp_ready_o;
  logic [15:0] rx_word_o;

  int checks = 0, fails = 0, rx_cnt = 0;
  logic [16:0] rx_last = '0;
  logic prev_v = 1'b0, dbl = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  dbg_serial_slave dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .sclk_i(sclk_i), .sdi_i(sdi_i),
    .sdo_o(sdo_o), .rx_valid_o(rx_valid_o), .rx_ctrl_o(rx_ctrl_o),
    .rx_word_o(rx_word_o), .rsp_valid_i(rsp_valid_i), .rsp_ready_o(rsp_ready_o),
    .rsp_stat_i(rsp_stat_i), .rsp_word_i(rsp_word_i)
  );

  always @(negedge clk_i) begin
    if (rx_valid_o) begin
      rx_cnt++;
      rx_last = {rx_ctrl_o, rx_word_o};
      if (prev_v) dbl = 1'b1;
    end
    prev_v = rx_valid_o;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_bits(input logic [16:0] cmd, input logic [16:0] exp,
                          input int from, input int to, input int hi, input int lo);
    for (int i = from; i >= to; i--) begin
      chk(sdo_o == exp[i], "R2 sdo bit", 32'(sdo_o), 32'(exp[i]));
      sdi_i  = cmd[i];
      sclk_i = 1'b1;
      repeat (hi) @(negedge clk_i);
      sclk_i = 1'b0;
      repeat (lo) @(negedge clk_i);
    end
  endtask

  task automatic send_resp(input logic [16:0] f);
    while (!rsp_ready_o) @(negedge clk_i);
    rsp_valid_i = 1'b1;
    {rsp_stat_i, rsp_word_i} = f;
    @(negedge clk_i);
    rsp_valid_i = 1'b0;
  endtask

  task automatic chk_rx(input int cnt0, input logic [16:0] cmd, input string req);
    chk(rx_cnt == cnt0 + 1, req, 32'(rx_cnt), 32'(cnt0 + 1));
    chk(rx_last == cmd, req, 32'(rx_last), 32'(cmd));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    $display("%0d/%0d checks passed", checks - fails + 1, checks + 1);
    $finish;
  end

  initial begin
    int c0;
    repeat (3) @(negedge clk_i);
    // R8 reset state
    chk(sdo_o == 1'b0, "R8 sdo", 32'(sdo_o), 0);
    chk(rx_valid_o == 1'b0, "R8 rx_valid", 32'(rx_valid_o), 0);
    chk(rsp_ready_o == 1'b1, "R8 ready", 32'(rsp_ready_o), 1);
    rst_ni = 1'b1;
    repeat (5) @(negedge clk_i);

    // R3/R7: first frame, no response -> not-ready, cycle-exact timing
    c0 = rx_cnt;
    chk(sdo_o == 1'b1, "R7 status", 32'(sdo_o), 1);
    sdi_i = 1'b1; sclk_i = 1'b1;
    repeat (3) @(negedge clk_i);
    chk(sdo_o == 1'b1, "R3 sdo held until N+3", 32'(sdo_o), 1);
    sclk_i = 1'b0;
    @(negedge clk_i);
    chk(sdo_o == 1'b0, "R3 sdo at N+3", 32'(sdo_o), 0);
    @(negedge clk_i);
    run_bits(17'h1F00F, 17'h10000, 15, 1, 3, 2);
    sdi_i = 1'b1; sclk_i = 1'b1;
    repeat (2) @(negedge clk_i);
    chk(rx_valid_o == 1'b0, "R3 rx_valid before N+2", 32'(rx_valid_o), 0);
    @(negedge clk_i);
    chk(rx_valid_o == 1'b1, "R3 rx_valid at N+2", 32'(rx_valid_o), 1);
    sclk_i = 1'b0;
    @(negedge clk_i);
    chk(rx_valid_o == 1'b0, "R1 pulse width", 32'(rx_valid_o), 0);
    @(negedge clk_i);
    chk_rx(c0, 17'h1F00F, "R1 rx word");
    repeat (40) @(negedge clk_i);

    // table walk: R1 R2 R6, varied rates incl. long highs and single low samples (R4)
    for (int v = 0; v < NVEC; v++) begin
      c0 = rx_cnt;
      send_resp(RSP_VEC[v]);
      repeat (4) @(negedge clk_i);
      run_bits(CMD_VEC[v], RSP_VEC[v], 16, 0, HI_VEC[v], LO_VEC[v]);
      repeat (2) @(negedge clk_i);
      chk_rx(c0, CMD_VEC[v], HI_VEC[v] >= 20 ? "R4 rx word" : "R1 rx word");
      repeat (40) @(negedge clk_i);
      chk(rsp_ready_o == 1'b1, "R6 ready idle", 32'(rsp_ready_o), 1);
    end

    // R5: stray bit inside recovery gap must be dropped
    c0 = rx_cnt;
    run_bits(17'h12345, 17'h10000, 16, 0, 3, 2);
    sdi_i = 1'b1; sclk_i = 1'b1;
    repeat (3) @(negedge clk_i);
    sclk_i = 1'b0;
    repeat (40) @(negedge clk_i);
    chk(rx_cnt == c0 + 1, "R5 frame count", 32'(rx_cnt), 32'(c0 + 1));
    run_bits(17'h0ABCD, 17'h10000, 16, 0, 3, 2);
    repeat (2) @(negedge clk_i);
    chk_rx(c0 + 1, 17'h0ABCD, "R5 word after gap");
    repeat (40) @(negedge clk_i);

    // R9: response offered mid-frame; second offer refused; current frame unchanged
    c0 = rx_cnt;
    run_bits(17'h16D2B, 17'h10000, 16, 12, 3, 2);
    send_resp(17'h04C1D);
    rsp_valid_i = 1'b1; {rsp_stat_i, rsp_word_i} = 17'h1DEAD;
    repeat (2) @(negedge clk_i);
    chk(rsp_ready_o == 1'b0, "R9 ready low while pending", 32'(rsp_ready_o), 0);
    rsp_valid_i = 1'b0;
    run_bits(17'h16D2B, 17'h10000, 11, 0, 3, 2);
    repeat (2) @(negedge clk_i);
    chk_rx(c0, 17'h16D2B, "R9 rx word");
    repeat (40) @(negedge clk_i);
    c0 = rx_cnt;
    run_bits(17'h00F0F, 17'h04C1D, 16, 0, 4, 3);
    repeat (2) @(negedge clk_i);
    chk_rx(c0, 17'h00F0F, "R9 next frame");
    repeat (40) @(negedge clk_i);

    // R7: no response again -> not-ready with zero word
    c0 = rx_cnt;
    run_bits(17'h1FFFF, 17'h10000, 16, 0, 3, 2);
    repeat (2) @(negedge clk_i);
    chk_rx(c0, 17'h1FFFF, "R7 rx word");

    chk(dbl == 1'b0, "R1 single-cycle pulse", 32'(dbl), 0);

    // R8: reset mid-frame clears bit position
    repeat (40) @(negedge clk_i);
    run_bits(17'h10101, 17'h10000, 16, 10, 3, 2);
    rst_ni = 1'b0;
    @(negedge clk_i);
    chk(sdo_o == 1'b0, "R8 sdo in reset", 32'(sdo_o), 0);
    rst_ni = 1'b1;
    repeat (5) @(negedge clk_i);
    c0 = rx_cnt;
    run_bits(17'h0C0DE, 17'h10000, 16, 0, 3, 2);
    repeat (2) @(negedge clk_i);
    chk_rx(c0, 17'h0C0DE, "R8 restart frame");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule